// File: doc/BRIEF.md
# Vector Element Swizzle Unit

The unit rebuilds a short vector of two to four 32-bit single-precision elements from one source vector. Each destination lane owns a 3-bit selector. A selector can copy any source lane into its lane, place one of three floating-point constants there, or leave the lane unwritten so that it keeps the old destination value. A per-lane write-enable output reports which lanes received new data.

The source length and the destination length are separate inputs. A short source vector can therefore feed a longer destination, and a long source can feed a shorter one. Destination lanes past the destination length are never written. A selector that names a source lane past the source length produces zero in that lane.

The result passes through one optional register stage, which is on by default. With the register in place, `valid_o` and the results follow `valid_i` and its operands by one clock cycle.

Top module: `vec_swizzle`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `wen_o` and `dst_o` are all zero.
- R2: With the default register stage, `valid_o` equals `valid_i` from one cycle earlier, and each result belongs to the operands presented in that cycle.
- R3: The selector for destination lane i is `sel_i[3i+2:3i]`, with lane 0 (X) in the least significant bits, followed by lanes 1 (Y), 2 (Z) and 3 (W). Lane i of `src_i`, `old_dst_i` and `dst_o` is bits [32i+31:32i].
- R4: Selector code 3'b1NN writes source lane NN (0..3) into the destination lane and sets that lane's write-enable. Any source lane may feed any destination lane, and one source lane may feed several.
- R5: Code 3'b001 writes 32'h00000000 (0.0), code 3'b010 writes 32'h3F800000 (+1.0) and code 3'b011 writes 32'hBF800000 (-1.0). Each sets the lane's write-enable.
- R6: Code 3'b000 masks the lane. The lane outputs its `old_dst_i` element unchanged and its write-enable is 0.
- R7: A destination lane i with i >= `dst_len_i` is masked whatever its selector holds. It outputs the old element and its write-enable is 0.
- R8: A code 3'b1NN with NN >= `src_len_i` writes 32'h00000000, and the lane's write-enable stays 1.
- R9: `src_len_i` and `dst_len_i` act independently. Each is an element count, normally 2, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands valid this cycle |
| src_i | input | 128 | Source vector, lane i at [32i+31:32i] |
| old_dst_i | input | 128 | Previous destination vector |
| sel_i | input | 12 | Packed per-lane selectors, lane i at [3i+2:3i] |
| src_len_i | input | 3 | Source element count |
| dst_len_i | input | 3 | Destination element count |
| valid_o | output | 1 | Result valid |
| dst_o | output | 128 | New destination vector |
| wen_o | output | 4 | Per-lane write-enable |

## Verification
The bench aims at four kinds of wrong behaviour:
- Lane selection: reversed and broadcast swizzles catch a design that reads a neighbour's selector bits or ignores the lane index.
- Constants: each constant code is checked with its exact bit pattern, so a swapped sign bit or a wrong exponent shows up.
- Masking: masked lanes and lanes beyond the destination length are checked against the old element with the write-enable low, which catches a design that passes source data through or leaves the enable high.
- Length handling: out-of-range source indices under several source/destination length pairs must give zero with the enable high, which exposes a design that ties the two lengths together or reads stale source lanes.

// File: rtl/vswz_pkg.sv
package vswz_pkg;
  localparam int unsigned ELEM_W    = 32;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MAX_LANES = 4;

  localparam logic [ELEM_W-1:0] FP_ZERO    = 32'h0000_0000;
  localparam logic [ELEM_W-1:0] FP_POS_ONE = 32'h3F80_0000;
  localparam logic [ELEM_W-1:0] FP_NEG_ONE = 32'hBF80_0000;

  typedef enum logic [SEL_W-1:0] {
    SEL_KEEP  = 3'b000,
    SEL_ZERO  = 3'b001,
    SEL_P_ONE = 3'b010,
    SEL_N_ONE = 3'b011,
    SEL_LN0   = 3'b100,
    SEL_LN1   = 3'b101,
    SEL_LN2   = 3'b110,
    SEL_LN3   = 3'b111
  } sel_code_e;
endpackage

// File: rtl/vswz_len_decode.sv
module vswz_len_decode #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned OUT_N     = 4,
  parameter int unsigned LEN_W     = 3
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [OUT_N-1:0] act_o
);
  // lane i is live when it is a real lane and below the element count
  for (genvar i = 0; i < OUT_N; i++) begin : g_act
    if (i < NUM_LANES) begin : g_live
      assign act_o[i] = (len_i > LEN_W'(i));
    end else begin : g_pad
      assign act_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vswz_lane_mux.sv
module vswz_lane_mux
  import vswz_pkg::*;
(
  input  logic [ELEM_W-1:0]    src_i [MAX_LANES],
  input  logic [MAX_LANES-1:0] src_act_i,
  input  logic [ELEM_W-1:0]    old_i,
  input  logic [SEL_W-1:0]     code_i,
  input  logic                 dst_act_i,
  output logic [ELEM_W-1:0]    elem_o,
  output logic                 wen_o
);
  logic [1:0] idx;
  assign idx = code_i[1:0];

  always_comb begin
    elem_o = old_i;
    wen_o  = 1'b0;
    if (dst_act_i) begin
      unique case (sel_code_e'(code_i))
        SEL_KEEP:  begin elem_o = old_i;      wen_o = 1'b0; end
        SEL_ZERO:  begin elem_o = FP_ZERO;    wen_o = 1'b1; end
        SEL_P_ONE: begin elem_o = FP_POS_ONE; wen_o = 1'b1; end
        SEL_N_ONE: begin elem_o = FP_NEG_ONE; wen_o = 1'b1; end
        default: begin
          elem_o = src_act_i[idx] ? src_i[idx] : FP_ZERO;
          wen_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/vswz_out_stage.sv
module vswz_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/vec_swizzle.sv
module vec_swizzle
  import vswz_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter bit          REG_OUT   = 1'b1,
  parameter int unsigned LEN_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NUM_LANES*ELEM_W-1:0]   src_i,
  input  logic [NUM_LANES*ELEM_W-1:0]   old_dst_i,
  input  logic [NUM_LANES*SEL_W-1:0]    sel_i,
  input  logic [LEN_W-1:0]              src_len_i,
  input  logic [LEN_W-1:0]              dst_len_i,
  output logic                          valid_o,
  output logic [NUM_LANES*ELEM_W-1:0]   dst_o,
  output logic [NUM_LANES-1:0]          wen_o
);
  localparam int unsigned VEC_W = NUM_LANES * ELEM_W;
  localparam int unsigned PAY_W = 1 + NUM_LANES + VEC_W;

  logic [ELEM_W-1:0]    src_pad [MAX_LANES];
  logic [MAX_LANES-1:0] src_act;
  logic [NUM_LANES-1:0] dst_act;
  logic [VEC_W-1:0]     dst_d;
  logic [NUM_LANES-1:0] wen_d;
  logic [PAY_W-1:0]     pay_q;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_pad
    if (j < NUM_LANES) begin : g_src
      assign src_pad[j] = src_i[j*ELEM_W +: ELEM_W];
    end else begin : g_zero
      assign src_pad[j] = FP_ZERO;
    end
  end

  vswz_len_decode #(.NUM_LANES(NUM_LANES), .OUT_N(MAX_LANES), .LEN_W(LEN_W)) u_src_len (
    .len_i (src_len_i),
    .act_o (src_act)
  );

  vswz_len_decode #(.NUM_LANES(NUM_LANES), .OUT_N(NUM_LANES), .LEN_W(LEN_W)) u_dst_len (
    .len_i (dst_len_i),
    .act_o (dst_act)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    vswz_lane_mux u_mux (
      .src_i     (src_pad),
      .src_act_i (src_act),
      .old_i     (old_dst_i[i*ELEM_W +: ELEM_W]),
      .code_i    (sel_i[i*SEL_W +: SEL_W]),
      .dst_act_i (dst_act[i]),
      .elem_o    (dst_d[i*ELEM_W +: ELEM_W]),
      .wen_o     (wen_d[i])
    );
  end

  vswz_out_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({valid_i, wen_d, dst_d}),
    .q_o    (pay_q)
  );

  assign {valid_o, wen_o, dst_o} = pay_q;
endmodule

// File: rtl/vswz_checker.sv
module vswz_checker #(
  parameter int unsigned NUM_LANES = 4,
  parameter bit          REG_OUT   = 1'b1,
  parameter int unsigned LEN_W     = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [NUM_LANES*32-1:0]   old_dst_i,
  input logic [NUM_LANES*3-1:0]    sel_i,
  input logic [LEN_W-1:0]          src_len_i,
  input logic [LEN_W-1:0]          dst_len_i,
  input logic                      valid_o,
  input logic [NUM_LANES*32-1:0]   dst_o,
  input logic [NUM_LANES-1:0]      wen_o
);
  if (REG_OUT) begin : g_chk
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        p_reset_clear_r1: assert (!valid_o && wen_o == '0 && dst_o == '0);
      end
    end

    p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_i));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_ln
      p_keep_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && $past(sel_i[3*i +: 3] == 3'b000)
        |-> !wen_o[i] && dst_o[32*i +: 32] == $past(old_dst_i[32*i +: 32]));

      p_beyond_dst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && $past(dst_len_i <= LEN_W'(i))
        |-> !wen_o[i] && dst_o[32*i +: 32] == $past(old_dst_i[32*i +: 32]));

      p_pos_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && $past(sel_i[3*i +: 3] == 3'b010 && dst_len_i > LEN_W'(i))
        |-> wen_o[i] && dst_o[32*i +: 32] == 32'h3F80_0000);

      p_src_oob_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && $past(sel_i[3*i + 2] && dst_len_i > LEN_W'(i)
                         && src_len_i <= LEN_W'(sel_i[3*i +: 2]))
        |-> wen_o[i] && dst_o[32*i +: 32] == 32'h0);
    end
  end
endmodule

bind vec_swizzle vswz_checker #(
  .NUM_LANES (NUM_LANES),
  .REG_OUT   (REG_OUT),
  .LEN_W     (LEN_W)
) u_vswz_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .old_dst_i (old_dst_i),
  .sel_i     (sel_i),
  .src_len_i (src_len_i),
  .dst_len_i (dst_len_i),
  .valid_o   (valid_o),
  .dst_o     (dst_o),
  .wen_o     (wen_o)
);

// File: tb/vec_swizzle_bench.sv
`timescale 1ns/1ps
module vec_swizzle_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] old_i = '0;
  logic [11:0]  sel_i = '0;
  logic [2:0]   sl_i = 3'd4;
  logic [2:0]   dl_i = 3'd4;
  logic         valid_o;
  logic [127:0] dst_o;
  logic [3:0]   wen_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [127:0] dst;
    logic [3:0]   wen;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  vec_swizzle u_vec_swizzle (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i),
    .src_i (src_i), .old_dst_i (old_i), .sel_i (sel_i),
    .src_len_i (sl_i), .dst_len_i (dl_i),
    .valid_o (valid_o), .dst_o (dst_o), .wen_o (wen_o)
  );

  function automatic item_t model(logic [127:0] s, logic [127:0] o, logic [11:0] sel,
                                  int sl, int dl, string tag);
    item_t it;
    it.tag = tag;
    for (int i = 0; i < 4; i++) begin
      logic [2:0] c;
      c = sel[3*i +: 3];
      it.dst[32*i +: 32] = o[32*i +: 32];
      it.wen[i] = 1'b0;
      if (i < dl && c != 3'b000) begin
        it.wen[i] = 1'b1;
        case (c)
          3'b001: it.dst[32*i +: 32] = 32'h0000_0000;
          3'b010: it.dst[32*i +: 32] = 32'h3F80_0000;
          3'b011: it.dst[32*i +: 32] = 32'hBF80_0000;
          default: it.dst[32*i +: 32] = (int'(c[1:0]) < sl) ? s[32*int'(c[1:0]) +: 32] : 32'h0;
        endcase
      end
    end
    return it;
  endfunction

  task automatic drive(logic [127:0] s, logic [127:0] o, logic [11:0] sel,
                       int sl, int dl, string tag);
    @(negedge clk);
    valid_i = 1'b1; src_i = s; old_i = o; sel_i = sel;
    sl_i = 3'(sl); dl_i = 3'(dl);
    sb_q.push_back(model(s, o, sel, sl, dl, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R2: valid_o=1 with nothing expected (act dst=%h wen=%b, exp valid_o=0)",
                 dst_o, wen_o);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        if (dst_o !== e.dst || wen_o !== e.wen) begin
          fails++;
          $display("FAIL %s: act dst=%h wen=%b exp dst=%h wen=%b",
                   e.tag, dst_o, wen_o, e.dst, e.wen);
        end
      end
    end
  end

  function automatic logic [11:0] pack(int l0, int l1, int l2, int l3);
    return {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
  endfunction

  localparam logic [127:0] SRC_A = {32'h4040_0000, 32'h4000_0000, 32'h3F00_0000, 32'h4120_0000};
  localparam logic [127:0] OLD_A = {32'hDEAD_0003, 32'hDEAD_0002, 32'hDEAD_0001, 32'hDEAD_0000};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || wen_o !== 4'b0 || dst_o !== '0) begin
      fails++;
      $display("FAIL R1: act v=%b wen=%b dst=%h exp all zero", valid_o, wen_o, dst_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    drive(SRC_A, OLD_A, pack(4, 5, 6, 7), 4, 4, "R4 identity");
    drive(SRC_A, OLD_A, pack(7, 6, 5, 4), 4, 4, "R3 reverse");
    drive(SRC_A, OLD_A, pack(6, 6, 6, 6), 4, 4, "R4 broadcast");
    drive(SRC_A, OLD_A, pack(1, 2, 3, 2), 4, 4, "R5 constants");
    drive(SRC_A, OLD_A, pack(0, 5, 0, 3), 4, 4, "R6 masked");
    drive(SRC_A, OLD_A, pack(0, 0, 0, 0), 4, 4, "R6 all masked");
    drive(SRC_A, OLD_A, pack(4, 5, 2, 7), 4, 2, "R7 dst len 2");
    drive(SRC_A, OLD_A, pack(5, 1, 4, 3), 4, 3, "R7 dst len 3");
    drive(SRC_A, OLD_A, pack(7, 6, 5, 4), 2, 4, "R8 src len 2");
    drive(SRC_A, OLD_A, pack(7, 6, 5, 4), 3, 4, "R8 src len 3");
    idle();
    idle();
    drive(SRC_A, OLD_A, pack(5, 4, 5, 4), 2, 4, "R9 src2 dst4");
    drive(SRC_A, OLD_A, pack(7, 6, 5, 4), 4, 2, "R9 src4 dst2");
    drive(SRC_A, OLD_A, pack(6, 4, 7, 4), 3, 3, "R9 src3 dst3");
    idle();

    for (int n = 0; n < 60; n++) begin
      logic [127:0] s, o;
      s = {$urandom, $urandom, $urandom, $urandom};
      o = {$urandom, $urandom, $urandom, $urandom};
      drive(s, o, 12'($urandom), 2 + int'($urandom % 3), 2 + int'($urandom % 3), "R2 random");
      if (n % 7 == 3) idle();
    end
    idle();
    repeat (4) @(negedge clk);

    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R2: act pending=%0d exp pending=0", sb_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule